// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Multiframe Aligner and Generator

This block builds and recovers the 16-frame signaling multiframe that an E1 (PCM30) link carries in timeslot 16. On the transmit side it keeps a frame index that advances on a frame-start strobe. When the line logic asks for the timeslot-16 byte, the block returns one of two things. In frame 0 it returns the alignment word: a zero nibble, three spare bits and the remote alarm bit. In frames 1 to 15 it returns two channels' ABCD signaling nibbles, and a channel marked clear is replaced by all ones.

On the receive side the block watches the incoming timeslot-16 bytes and looks for the all-zero alignment nibble. It declares multiframe lock when it finds one, and drops lock after a run of errored alignment words. While locked it sorts the received nibbles into a per-channel signaling register file and reports the far end's alarm bit. The transmitted alarm bit follows the local receive lock, so the far end learns when this side has lost multiframe alignment. Basic frame alignment and CRC-4 multiframing happen elsewhere. The signaling multiframe keeps its own phase, which need not line up with any CRC-4 multiframe.

Top module: `cas_mf_codec`

## Requirements
- R1: The first `tx_fs` pulse after reset starts transmit frame 0. Each later `tx_fs` advances the frame index, from 15 back to 0. A `tx_req` pulse loads `tx_byte` with the byte for the current frame and raises `tx_vld` for one cycle, one clock after the request.
- R2: In frame 0, `tx_byte[7:4]` is 0000 and the spare bits `tx_byte[3]`, `tx_byte[1]` and `tx_byte[0]` are 1.
- R3: In frame 0, `tx_byte[2]` (the remote alarm bit) is 0 while `rx_lock` is 1 and 1 while `rx_lock` is 0.
- R4: In frame n (1 to 15), `tx_byte[7:4]` carries channel n and `tx_byte[3:0]` carries channel n+15. Channel k (1 to 30) takes its nibble from `tx_sig[4k-1:4k-4]`, with A on nibble bit 3, B on bit 2, C on bit 1 and D on bit 0.
- R5: When `tx_clear[k-1]` is 1, channel k's nibble is sent as 1111 whatever `tx_sig` holds.
- R6: While not locked, a received byte whose bits [7:4] are 0000 sets `rx_lock` one clock after its `rx_vld`, but only if the previously received byte was not 00h. That frame becomes receive frame 0. If the previous byte was 00h, or no byte has yet been received, lock is not declared.
- R7: While locked, each frame-0 byte whose bits [7:4] are not 0000 counts as one errored word, and a correct word clears the count. Lock drops after LOSS_THRESH (default 2) consecutive errored words, so a single errored word followed by a correct one leaves lock held.
- R8: While locked, a byte received in frame n (1 to 15) writes its upper nibble to channel n and its lower nibble to channel n+15 of `rx_sig`, using the same layout as `tx_sig`. Bytes received while unlocked leave `rx_sig` unchanged.
- R9: `rx_far_alarm` takes bit 2 of the locking word and of each correct alignment word. It is 0 whenever `rx_lock` is 0.
- R10: After reset, `tx_vld` is 0, `tx_byte` is FFh, `rx_lock` is 0, `rx_far_alarm` is 0 and every `rx_sig` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_fs | input | 1 | Transmit basic-frame start strobe |
| tx_req | input | 1 | Request for the transmit timeslot-16 byte |
| tx_sig | input | 120 | Transmit ABCD nibbles, channel k at [4k-1:4k-4] |
| tx_clear | input | 30 | Per-channel clear flag, channel k at bit k-1 |
| tx_byte | output | 8 | Transmit timeslot-16 byte |
| tx_vld | output | 1 | `tx_byte` updated this cycle |
| rx_fs | input | 1 | Receive basic-frame start strobe |
| rx_vld | input | 1 | Receive timeslot-16 byte strobe |
| rx_byte | input | 8 | Received timeslot-16 byte |
| rx_lock | output | 1 | Receive multiframe lock |
| rx_far_alarm | output | 1 | Far-end multiframe alarm bit |
| rx_sig | output | 120 | Received ABCD nibbles, channel k at [4k-1:4k-4] |

## Verification
The bench builds the block with its defaults, MF_LEN=16 and LOSS_THRESH=2. This is small enough to sweep every transmit frame position and all 30 channel slots in both directions, with signaling values and clear masks computed arithmetically from a seed. The two-word loss threshold lets a short stream exercise a single tolerated error, a recovery, and an actual loss of lock, along with the zero-predecessor rule that blocks a false lock.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;

   // Frame-0 word: zero alignment nibble, spare bits high, alarm bit at [2]
   function automatic logic [BYTE_W-1:0] align_word(input logic alarm);
      return {4'b0000, 1'b1, alarm, 1'b1, 1'b1};
   endfunction
endpackage

// File: rtl/cas_mf_tx.sv
module cas_mf_tx
   import cas_mf_pkg::*;
#(
   parameter int unsigned MF_LEN = 16,
   parameter int unsigned NCH    = 30,
   parameter int unsigned FW     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fs,
   input  logic                    req,
   input  logic [NCH*NIB_W-1:0]    sig,
   input  logic [NCH-1:0]          clr,
   input  logic                    alarm,
   output logic [FW-1:0]           idx,
   output logic [BYTE_W-1:0]       byte_o,
   output logic                    vld_o
);
   localparam int unsigned HALF = MF_LEN - 1;
   localparam logic [FW-1:0] LAST_IDX = FW'(MF_LEN - 1);

   logic [BYTE_W-1:0] frame_word [MF_LEN];

   assign frame_word[0] = align_word(alarm);

   for (genvar g = 1; g < MF_LEN; g++) begin : g_frame
      logic [NIB_W-1:0] hi_nib, lo_nib;
      assign hi_nib = clr[g-1]      ? {NIB_W{1'b1}} : sig[(g-1)*NIB_W +: NIB_W];
      assign lo_nib = clr[g-1+HALF] ? {NIB_W{1'b1}} : sig[(g-1+HALF)*NIB_W +: NIB_W];
      assign frame_word[g] = {hi_nib, lo_nib};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= LAST_IDX;
         byte_o <= {BYTE_W{1'b1}};
         vld_o  <= 1'b0;
      end else begin
         if (fs) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
         vld_o <= req;
         if (req) byte_o <= frame_word[idx];
      end
   end
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align
   import cas_mf_pkg::*;
#(
   parameter int unsigned MF_LEN      = 16,
   parameter int unsigned LOSS_THRESH = 2,
   parameter int unsigned FW          = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs,
   input  logic              vld,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              lock_o,
   output logic [FW-1:0]     idx_o,
   output logic              far_o
);
   localparam int unsigned LW = $clog2(LOSS_THRESH + 1);
   localparam logic [FW-1:0] LAST_IDX = FW'(MF_LEN - 1);
   localparam logic [LW-1:0] LAST_ERR = LW'(LOSS_THRESH - 1);

   logic [BYTE_W-1:0] prev_byte;
   logic              prev_ok;
   logic [LW-1:0]     err_cnt;
   logic              fas_hit;

   assign fas_hit = (byte_i[BYTE_W-1 -: NIB_W] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_byte <= '0;
         prev_ok   <= 1'b0;
         err_cnt   <= '0;
         lock_o    <= 1'b0;
         idx_o     <= '0;
         far_o     <= 1'b0;
      end else begin
         if (fs && lock_o) idx_o <= (idx_o == LAST_IDX) ? '0 : idx_o + 1'b1;
         if (vld) begin
            prev_byte <= byte_i;
            prev_ok   <= 1'b1;
            if (!lock_o) begin
               if (fas_hit && prev_ok && (prev_byte != '0)) begin
                  lock_o  <= 1'b1;
                  idx_o   <= '0;
                  err_cnt <= '0;
                  far_o   <= byte_i[2];
               end
            end else if (idx_o == '0) begin
               if (fas_hit) begin
                  err_cnt <= '0;
                  far_o   <= byte_i[2];
               end else if (err_cnt == LAST_ERR) begin
                  lock_o  <= 1'b0;
                  far_o   <= 1'b0;
                  err_cnt <= '0;
               end else begin
                  err_cnt <= err_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cas_mf_sig_store.sv
module cas_mf_sig_store
   import cas_mf_pkg::*;
#(
   parameter int unsigned MF_LEN = 16,
   parameter int unsigned NCH    = 30,
   parameter int unsigned FW     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [FW-1:0]        idx,
   input  logic [BYTE_W-1:0]    byte_i,
   output logic [NCH*NIB_W-1:0] sig_o
);
   localparam int unsigned HALF = MF_LEN - 1;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      localparam bit          UPPER = (c < HALF);
      localparam int unsigned FRM   = UPPER ? c + 1 : c - HALF + 1;
      logic [NIB_W-1:0] nib;
      assign nib = UPPER ? byte_i[BYTE_W-1 -: NIB_W] : byte_i[NIB_W-1:0];
      always_ff @(posedge clk) begin
         if (!rst_n) sig_o[c*NIB_W +: NIB_W] <= {NIB_W{1'b1}};
         else if (wr && idx == FW'(FRM)) sig_o[c*NIB_W +: NIB_W] <= nib;
      end
   end
endmodule

// File: rtl/cas_mf_codec.sv
module cas_mf_codec
   import cas_mf_pkg::*;
#(
   parameter int unsigned MF_LEN      = 16,
   parameter int unsigned LOSS_THRESH = 2,
   localparam int unsigned NCH        = 2 * (MF_LEN - 1),
   localparam int unsigned FW         = $clog2(MF_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_fs,
   input  logic                 tx_req,
   input  logic [NCH*NIB_W-1:0] tx_sig,
   input  logic [NCH-1:0]       tx_clear,
   output logic [BYTE_W-1:0]    tx_byte,
   output logic                 tx_vld,
   input  logic                 rx_fs,
   input  logic                 rx_vld,
   input  logic [BYTE_W-1:0]    rx_byte,
   output logic                 rx_lock,
   output logic                 rx_far_alarm,
   output logic [NCH*NIB_W-1:0] rx_sig
);
   initial begin
      assert (MF_LEN >= 2 && MF_LEN == (1 << FW))
         else $error("MF_LEN must be a power of two, at least 2");
      assert (LOSS_THRESH >= 1)
         else $error("LOSS_THRESH must be at least 1");
   end

   logic [FW-1:0] tx_idx;
   logic [FW-1:0] rx_idx;
   logic          sig_wr;

   cas_mf_tx #(.MF_LEN(MF_LEN), .NCH(NCH), .FW(FW)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .fs    (tx_fs),
      .req   (tx_req),
      .sig   (tx_sig),
      .clr   (tx_clear),
      .alarm (!rx_lock),
      .idx   (tx_idx),
      .byte_o(tx_byte),
      .vld_o (tx_vld)
   );

   cas_mf_align #(.MF_LEN(MF_LEN), .LOSS_THRESH(LOSS_THRESH), .FW(FW)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .fs    (rx_fs),
      .vld   (rx_vld),
      .byte_i(rx_byte),
      .lock_o(rx_lock),
      .idx_o (rx_idx),
      .far_o (rx_far_alarm)
   );

   assign sig_wr = rx_vld && rx_lock && (rx_idx != '0);

   cas_mf_sig_store #(.MF_LEN(MF_LEN), .NCH(NCH), .FW(FW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (sig_wr),
      .idx   (rx_idx),
      .byte_i(rx_byte),
      .sig_o (rx_sig)
   );
endmodule

// File: rtl/cas_mf_chk.sv
module cas_mf_chk #(
   parameter int unsigned NCH = 30,
   parameter int unsigned FW  = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tx_req,
   input logic [FW-1:0]  tx_idx,
   input logic [7:0]     tx_byte,
   input logic [NCH-1:0] tx_clear,
   input logic           rx_lock,
   input logic           rx_vld,
   input logic [7:0]     rx_byte,
   input logic [FW-1:0]  rx_idx,
   input logic           rx_far_alarm
);
   AST_TX_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_idx == '0 |=> tx_byte[7:4] == 4'h0 && tx_byte[3] && tx_byte[1] && tx_byte[0]); // R2
   AST_TX_ALARM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_idx == '0 |=> tx_byte[2] == !$past(rx_lock)); // R3
   AST_TX_CLEAR_HI: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_idx != '0 && tx_clear[tx_idx - 1'b1] |=> tx_byte[7:4] == 4'hF); // R5
   AST_LOCK_ON_ZERO_NIB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_lock) |-> $past(rx_vld) && $past(rx_byte[7:4]) == 4'h0 && rx_idx == '0); // R6
   AST_LOSS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_lock) |-> $past(rx_vld) && $past(rx_byte[7:4]) != 4'h0); // R7
   AST_FAR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_far_alarm |-> rx_lock); // R9
endmodule

bind cas_mf_codec cas_mf_chk #(.NCH(NCH), .FW(FW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_req      (tx_req),
   .tx_idx      (tx_idx),
   .tx_byte     (tx_byte),
   .tx_clear    (tx_clear),
   .rx_lock     (rx_lock),
   .rx_vld      (rx_vld),
   .rx_byte     (rx_byte),
   .rx_idx      (rx_idx),
   .rx_far_alarm(rx_far_alarm)
);

// File: tb/cas_mf_codec_bench.sv
module cas_mf_codec_bench;
   localparam int PERIOD = 10;
   localparam int MF     = 16;
   localparam int NCH    = 30;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_fs = 1'b0, tx_req = 1'b0;
   logic [NCH*4-1:0] tx_sig = '0;
   logic [NCH-1:0]   tx_clear = '0;
   logic [7:0]       tx_byte;
   logic             tx_vld;
   logic             rx_fs = 1'b0, rx_vld = 1'b0;
   logic [7:0]       rx_byte = '0;
   logic             rx_lock, rx_far_alarm;
   logic [NCH*4-1:0] rx_sig;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   cas_mf_codec u_cas_mf_codec (
      .clk(clk), .rst_n(rst_n),
      .tx_fs(tx_fs), .tx_req(tx_req), .tx_sig(tx_sig), .tx_clear(tx_clear),
      .tx_byte(tx_byte), .tx_vld(tx_vld),
      .rx_fs(rx_fs), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .rx_lock(rx_lock), .rx_far_alarm(rx_far_alarm), .rx_sig(rx_sig)
   );

   function automatic logic [3:0] sigv(int k, int seed);
      return 4'((k * 5 + seed) % 16);
   endfunction

   function automatic logic [7:0] exp_tx(int f, bit locked, int seed, logic [NCH-1:0] clr);
      logic [3:0] hi, lo;
      if (f == 0) return {4'h0, 1'b1, !locked, 1'b1, 1'b1};
      hi = clr[f-1]  ? 4'hF : sigv(f, seed);
      lo = clr[f+14] ? 4'hF : sigv(f + 15, seed);
      return {hi, lo};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_tx(int seed, logic [NCH-1:0] clr);
      for (int k = 1; k <= NCH; k++) tx_sig[(k-1)*4 +: 4] = sigv(k, seed);
      tx_clear = clr;
   endtask

   // one transmit frame: frame start, then byte request; sample after it registers
   task automatic tx_frame(output logic [7:0] b, output logic v);
      @(negedge clk) tx_fs = 1'b1;
      @(negedge clk) begin tx_fs = 1'b0; tx_req = 1'b1; end
      @(negedge clk) tx_req = 1'b0;
      b = tx_byte;
      v = tx_vld;
   endtask

   task automatic rx_frame(logic [7:0] b);
      @(negedge clk) rx_fs = 1'b1;
      @(negedge clk) begin rx_fs = 1'b0; rx_vld = 1'b1; rx_byte = b; end
      @(negedge clk) rx_vld = 1'b0;
   endtask

   task automatic rx_body(int seed);
      for (int f = 1; f < MF; f++) rx_frame({sigv(f, seed), sigv(f + 15, seed)});
   endtask

   task automatic check_rx_sig(string req, int seed);
      for (int k = 1; k <= NCH; k++)
         check(req, 32'(rx_sig[(k-1)*4 +: 4]), 32'(sigv(k, seed)));
   endtask

   task automatic tx_sweep(string req, bit locked, int seed, logic [NCH-1:0] clr);
      logic [7:0] b;
      logic       v;
      load_tx(seed, clr);
      for (int f = 0; f < MF; f++) begin
         tx_frame(b, v);
         check({req, " byte"}, 32'(b), 32'(exp_tx(f, locked, seed, clr)));
         check("R1 tx_vld", 32'(v), 32'd1);
      end
   endtask

   initial begin
      logic [7:0]       b;
      logic             v;
      logic [NCH-1:0]   mask;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 tx_vld", 32'(tx_vld), 32'd0);
      check("R10 tx_byte", 32'(tx_byte), 32'hFF);
      check("R10 rx_lock", 32'(rx_lock), 32'd0);
      check("R10 rx_far_alarm", 32'(rx_far_alarm), 32'd0);
      check("R10 rx_sig ones", 32'(rx_sig == '1), 32'd1);

      // R1 R2 R3 R4: full frame sweep, unlocked, no clear channels
      tx_sweep("R1 R2 R3 R4", 1'b0, 1, '0);
      @(negedge clk);
      check("R1 tx_vld pulse", 32'(tx_vld), 32'd0);
      // R5: every third channel cleared, plus both nibbles of one frame
      mask = '0;
      for (int k = 1; k <= NCH; k++) if (k % 3 == 0) mask[k-1] = 1'b1;
      mask[3] = 1'b1; mask[18] = 1'b1;
      tx_sweep("R5 R4", 1'b0, 2, mask);

      // R6: zero predecessor blocks lock
      rx_frame(8'h00);
      check("R6 no lock on first byte", 32'(rx_lock), 32'd0);
      rx_frame(8'h0F);
      check("R6 zero predecessor", 32'(rx_lock), 32'd0);
      check("R8 unlocked no write", 32'(rx_sig == '1), 32'd1);
      rx_frame(8'hA5);
      check("R6 nonzero upper", 32'(rx_lock), 32'd0);
      rx_frame(8'h0B);
      check("R6 lock declared", 32'(rx_lock), 32'd1);
      check("R9 alarm clear", 32'(rx_far_alarm), 32'd0);
      rx_body(3);
      check_rx_sig("R8 extract seed3", 3);
      rx_frame(8'h0F);
      check("R9 alarm set", 32'(rx_far_alarm), 32'd1);
      check("R7 lock held", 32'(rx_lock), 32'd1);

      // R3: transmit index is back at 15, next frame is 0 with lock held
      load_tx(4, '0);
      tx_frame(b, v);
      check("R3 alarm bit locked", 32'(b), 32'(exp_tx(0, 1'b1, 4, '0)));

      rx_body(6);
      check_rx_sig("R8 extract seed6", 6);
      rx_frame(8'h5F);
      check("R7 single error keeps lock", 32'(rx_lock), 32'd1);
      rx_body(9);
      check_rx_sig("R8 extract during error", 9);
      rx_frame(8'h0B);
      check("R7 recovered", 32'(rx_lock), 32'd1);
      check("R9 alarm follows word", 32'(rx_far_alarm), 32'd0);
      rx_frame(8'h0F);
      check("R7 wrong position", 32'(rx_lock), 32'd1);
      check("R9 alarm stays until frame 0", 32'(rx_far_alarm), 32'd0);
      for (int f = 2; f < MF; f++) rx_frame({sigv(f, 9), sigv(f + 15, 9)});
      rx_frame(8'h6F);
      check("R7 first error", 32'(rx_lock), 32'd1);
      rx_body(11);
      check_rx_sig("R8 extract seed11", 11);
      rx_frame(8'h7B);
      check("R7 lock lost", 32'(rx_lock), 32'd0);
      check("R9 alarm cleared", 32'(rx_far_alarm), 32'd0);
      rx_frame(8'h77);
      rx_frame(8'h99);
      check("R7 still searching", 32'(rx_lock), 32'd0);
      check_rx_sig("R8 unlocked keeps", 11);

      // R3 R4: sweep after loss of lock; index 0 was used, 15 frames remain before wrap
      load_tx(7, '0);
      for (int f = 1; f <= MF; f++) begin
         tx_frame(b, v);
         check("R3 R4 post-loss", 32'(b), 32'(exp_tx(f % MF, 1'b0, 7, '0)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule